// File: doc/BRIEF.md
# ATA PIO Register Access Sequencer

This block runs one programmed-I/O register access on a parallel ATA device bus. A one-cycle `go` pulse starts the access. The block captures the register address, the transfer direction and a timing profile at that moment. It then steps through four phases:

1. Address setup.
2. Strobe-active, which the device may lengthen through its ready line.
3. Data hold.
4. End-of-cycle recovery.

When the access ends, the block raises `done` for one cycle. On a read, it also returns the word it sampled from the bus.

The block can use three timing profiles. Each profile holds four 8-bit cycle counts and a ready-enable bit. A shared command profile serves every register that is not the data port. Each of the two attached devices also has its own data-port profile. A data-port access uses the selected device's profile only when that device's fast-timing flag is set; otherwise it uses the command profile. Chip selects, address pins, write-data registers and input synchronisers sit outside this block. The ready input arrives here already synchronised.

Top module: `ata_pio_sequencer`

## Requirements
- R1: While `rst_n` is low (asynchronous) or `srst` is high at a clock edge (synchronous), the block returns to idle. In that state `rd_strobe`, `wr_strobe`, `bus_oe` and `done` are low and `rd_data` is zero. A reset that arrives during an access abandons it, and no `done` follows.
- R2: A timing word packs four counts: setup in bits [7:0], active in [15:8], hold in [23:16] and recovery in [31:24]. A phase whose count is N lasts exactly N+1 clock cycles, so a count of 0 still gives one cycle. The strobe rises setup+1 cycles after the edge that samples `go`.
- R3: `done` is high for exactly one cycle, in the cycle after the recovery phase ends. That is setup+active_len+hold+recovery+3 cycles after the edge that samples `go`, where active_len is the length of the strobe-active phase.
- R4: A write (`dir_wr`=1) raises `wr_strobe` only during the active phase and never raises `rd_strobe`. It holds `bus_oe` high across setup, active and hold.
- R5: A read (`dir_wr`=0) raises `rd_strobe` only during the active phase and keeps `bus_oe` low. `rd_data` takes `bus_din` as sampled at the last active cycle. A write leaves `rd_data` unchanged.
- R6: Address 4'h0 is the data port. A data-port access uses `d0_tim`/`d0_rdy_en` when `dev_sel`=0 and `fast_en0`=1. It uses `d1_tim`/`d1_rdy_en` when `dev_sel`=1 and `fast_en1`=1.
- R7: Any address other than 4'h0 uses `cmd_tim`/`cmd_rdy_en`. A data-port access whose device has its fast flag clear also uses the command profile.
- R8: When the chosen profile's ready-enable is 1, a low `iordy_s` keeps the active phase going after its count expires. The phase ends at the first edge at which the count has expired and `iordy_s` is high.
- R9: When the chosen profile's ready-enable is 0, `iordy_s` has no effect on any phase length.
- R10: A `go` pulse that arrives while an access is in progress is ignored. No second access starts.
- R11: The address, direction, device select, fast flags and timing profile are taken when `go` is accepted. Changes to them during an access do not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous reset, active high |
| go | input | 1 | One-cycle start pulse |
| dir_wr | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register address; 4'h0 is the data port |
| dev_sel | input | 1 | Currently selected device |
| fast_en0 | input | 1 | Device 0 uses its own data-port profile |
| fast_en1 | input | 1 | Device 1 uses its own data-port profile |
| cmd_tim | input | 32 | Command profile counts {recovery, hold, active, setup} |
| cmd_rdy_en | input | 1 | Command profile honours ready |
| d0_tim | input | 32 | Device 0 data-port counts |
| d0_rdy_en | input | 1 | Device 0 profile honours ready |
| d1_tim | input | 32 | Device 1 data-port counts |
| d1_rdy_en | input | 1 | Device 1 profile honours ready |
| bus_din | input | 16 | Data from the device bus |
| iordy_s | input | 1 | Synchronised device ready |
| done | output | 1 | End-of-access pulse |
| rd_data | output | 16 | Last word read |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| bus_oe | output | 1 | Data-bus drive enable |

## Verification
The bench runs accesses with a count of zero in every phase. A design that skips a phase or counts N cycles in place of N+1 shows a wrong strobe start, strobe width or `done` time. Ready is held low past the active count both with the enable set and with it clear, which exposes a design that ignores the stretch or that stalls when it should not. The bench toggles the fast flags and picks both command and data addresses, so a design that picks the wrong profile produces a wrong width. A second `go`, sent together with a device-select change in mid-access, catches a design that restarts or takes its profile late. Both resets are applied in mid-access, which catches a design that leaves a strobe high or still emits `done`.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_RECOV  = 3'd4
    } ata_phase_e;

    typedef enum logic [1:0] {
        PROF_CMD  = 2'd0,
        PROF_DEV0 = 2'd1,
        PROF_DEV1 = 2'd2
    } ata_prof_e;
endpackage

// File: rtl/ata_pio_prof_sel.sv
module ata_pio_prof_sel
    import ata_pio_pkg::*;
#(
    parameter int TW        = 8,
    parameter int AW        = 4,
    parameter int DATA_ADDR = 0
) (
    input  logic [AW-1:0]   addr,
    input  logic            dev_sel,
    input  logic            fast_en0,
    input  logic            fast_en1,
    input  logic [4*TW-1:0] cmd_tim,
    input  logic            cmd_rdy_en,
    input  logic [4*TW-1:0] d0_tim,
    input  logic            d0_rdy_en,
    input  logic [4*TW-1:0] d1_tim,
    input  logic            d1_rdy_en,
    output ata_prof_e       prof,
    output logic [4*TW-1:0] sel_tim,
    output logic            sel_rdy_en
);
    localparam logic [AW-1:0] DPORT = AW'(DATA_ADDR);

    always_comb begin
        prof = PROF_CMD;
        if (addr == DPORT) begin
            if (!dev_sel && fast_en0)
                prof = PROF_DEV0;
            else if (dev_sel && fast_en1)
                prof = PROF_DEV1;
        end
    end

    always_comb begin
        case (prof)
            PROF_DEV0: begin sel_tim = d0_tim;  sel_rdy_en = d0_rdy_en;  end
            PROF_DEV1: begin sel_tim = d1_tim;  sel_rdy_en = d1_rdy_en;  end
            default:   begin sel_tim = cmd_tim; sel_rdy_en = cmd_rdy_en; end
        endcase
    end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int TW = 8,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            srst,
    input  logic            go,
    input  logic            dir_wr,
    input  logic [4*TW-1:0] tim,
    input  logic            rdy_en,
    input  logic [DW-1:0]   bus_din,
    input  logic            iordy_s,
    output logic            done,
    output logic [DW-1:0]   rd_data,
    output logic            rd_strobe,
    output logic            wr_strobe,
    output logic            bus_oe
);
    localparam int SETUP_LSB = 0;
    localparam int ACT_LSB   = TW;
    localparam int HOLD_LSB  = 2 * TW;
    localparam int REC_LSB   = 3 * TW;

    typedef struct packed {
        ata_phase_e    ph;
        logic [TW-1:0] cnt;
        logic          wr;
        logic          rdy_en;
        logic [TW-1:0] t_act;
        logic [TW-1:0] t_hold;
        logic [TW-1:0] t_rec;
        logic          done;
        logic [DW-1:0] rdat;
    } seq_t;

    seq_t st_d, st_q;
    logic cnt_zero_q;

    assign cnt_zero_q = (st_q.cnt == '0);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (go) begin
                    st_d.ph     = PH_SETUP;
                    st_d.cnt    = tim[SETUP_LSB +: TW];
                    st_d.t_act  = tim[ACT_LSB +: TW];
                    st_d.t_hold = tim[HOLD_LSB +: TW];
                    st_d.t_rec  = tim[REC_LSB +: TW];
                    st_d.wr     = dir_wr;
                    st_d.rdy_en = rdy_en;
                end
            end
            PH_SETUP: begin
                if (cnt_zero_q) begin
                    st_d.ph  = PH_ACTIVE;
                    st_d.cnt = st_q.t_act;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_ACTIVE: begin
                if (!cnt_zero_q) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else if (!(st_q.rdy_en && !iordy_s)) begin
                    st_d.ph  = PH_HOLD;
                    st_d.cnt = st_q.t_hold;
                    if (!st_q.wr)
                        st_d.rdat = bus_din;
                end
            end
            PH_HOLD: begin
                if (cnt_zero_q) begin
                    st_d.ph  = PH_RECOV;
                    st_d.cnt = st_q.t_rec;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_RECOV: begin
                if (cnt_zero_q) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else if (srst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign done      = st_q.done;
    assign rd_data   = st_q.rdat;
    assign rd_strobe = (st_q.ph == PH_ACTIVE) && !st_q.wr;
    assign wr_strobe = (st_q.ph == PH_ACTIVE) && st_q.wr;
    assign bus_oe    = st_q.wr && (st_q.ph == PH_SETUP || st_q.ph == PH_ACTIVE
                                   || st_q.ph == PH_HOLD);

    a_r1_sync_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (st_q.ph == PH_IDLE && !done));

    a_r2_phase_held_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE && !cnt_zero_q && !srst) |=> $stable(st_q.ph));

    a_r3_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

    a_r5_read_bus_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> !bus_oe);

    a_r8_ready_stretches: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_ACTIVE && cnt_zero_q && st_q.rdy_en && !iordy_s && !srst)
        |=> (st_q.ph == PH_ACTIVE && $stable(rd_strobe) && $stable(wr_strobe)));

    a_r10_no_restart_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph inside {PH_ACTIVE, PH_HOLD, PH_RECOV}) |=> st_q.ph != PH_SETUP);
endmodule

// File: rtl/ata_pio_sequencer.sv
module ata_pio_sequencer
    import ata_pio_pkg::*;
#(
    parameter int TW        = 8,
    parameter int DW        = 16,
    parameter int AW        = 4,
    parameter int DATA_ADDR = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            srst,
    input  logic            go,
    input  logic            dir_wr,
    input  logic [AW-1:0]   addr,
    input  logic            dev_sel,
    input  logic            fast_en0,
    input  logic            fast_en1,
    input  logic [4*TW-1:0] cmd_tim,
    input  logic            cmd_rdy_en,
    input  logic [4*TW-1:0] d0_tim,
    input  logic            d0_rdy_en,
    input  logic [4*TW-1:0] d1_tim,
    input  logic            d1_rdy_en,
    input  logic [DW-1:0]   bus_din,
    input  logic            iordy_s,
    output logic            done,
    output logic [DW-1:0]   rd_data,
    output logic            rd_strobe,
    output logic            wr_strobe,
    output logic            bus_oe
);
    ata_prof_e       prof;
    logic [4*TW-1:0] sel_tim;
    logic            sel_rdy_en;

    ata_pio_prof_sel #(.TW(TW), .AW(AW), .DATA_ADDR(DATA_ADDR)) u_prof_sel (
        .addr       (addr),
        .dev_sel    (dev_sel),
        .fast_en0   (fast_en0),
        .fast_en1   (fast_en1),
        .cmd_tim    (cmd_tim),
        .cmd_rdy_en (cmd_rdy_en),
        .d0_tim     (d0_tim),
        .d0_rdy_en  (d0_rdy_en),
        .d1_tim     (d1_tim),
        .d1_rdy_en  (d1_rdy_en),
        .prof       (prof),
        .sel_tim    (sel_tim),
        .sel_rdy_en (sel_rdy_en)
    );

    ata_pio_seq #(.TW(TW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .go        (go),
        .dir_wr    (dir_wr),
        .tim       (sel_tim),
        .rdy_en    (sel_rdy_en),
        .bus_din   (bus_din),
        .iordy_s   (iordy_s),
        .done      (done),
        .rd_data   (rd_data),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .bus_oe    (bus_oe)
    );

    a_r7_registers_use_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != AW'(DATA_ADDR)) |-> (prof == PROF_CMD && sel_tim == cmd_tim));

    a_r6_fast_device_profile: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(DATA_ADDR) && dev_sel && fast_en1) |-> (sel_tim == d1_tim));
endmodule

// File: tb/test_ata_pio_sequencer.sv
module test_ata_pio_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        srst = 1'b0;
    logic        go = 1'b0;
    logic        dir_wr = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic        dev_sel = 1'b0;
    logic        fast_en0 = 1'b0;
    logic        fast_en1 = 1'b0;
    logic [31:0] cmd_tim, d0_tim, d1_tim;
    logic        cmd_rdy_en = 1'b0, d0_rdy_en = 1'b1, d1_rdy_en = 1'b0;
    logic [15:0] bus_din = 16'h0;
    logic        iordy_s = 1'b1;
    logic        done, rd_strobe, wr_strobe, bus_oe;
    logic [15:0] rd_data;

    always #4 clk = ~clk;

    ata_pio_sequencer i_ata_pio_sequencer (
        .clk(clk), .rst_n(rst_n), .srst(srst), .go(go), .dir_wr(dir_wr),
        .addr(addr), .dev_sel(dev_sel), .fast_en0(fast_en0), .fast_en1(fast_en1),
        .cmd_tim(cmd_tim), .cmd_rdy_en(cmd_rdy_en), .d0_tim(d0_tim),
        .d0_rdy_en(d0_rdy_en), .d1_tim(d1_tim), .d1_rdy_en(d1_rdy_en),
        .bus_din(bus_din), .iordy_s(iordy_s), .done(done), .rd_data(rd_data),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .bus_oe(bus_oe)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    typedef struct {
        int          first;
        int          slen;
        int          oelen;
        int          done_at;
        bit          wr;
        logic [15:0] rd;
        string       tag;
    } item_t;

    item_t sb[$];
    bit    mon_en = 1'b1;
    bit    busy = 1'b0;
    bit    chk_done_low = 1'b0;
    int    cnt, first, slen, oelen;
    bit    saw_rd, saw_wr;
    logic [15:0] last_rd = 16'h0;

    function automatic logic [31:0] pack_tim(int s, int a, int h, int r);
        return {8'(r), 8'(h), 8'(a), 8'(s)};
    endfunction

    // Monitor: measures every access at the negative edge and compares with the queue
    always @(negedge clk) begin
        if (chk_done_low) begin
            chk_done_low = 1'b0;
            check(done == 1'b0, "R3 done longer than one cycle", done, 0);
        end
        if (mon_en) begin
            if (!busy) begin
                if (rd_strobe || wr_strobe)
                    check(1'b0, "R10 strobe with no accepted access", 1, 0);
                if (go) begin
                    busy = 1'b1; cnt = 0; first = -1; slen = 0; oelen = 0;
                    saw_rd = 1'b0; saw_wr = 1'b0;
                end
            end else begin
                cnt++;
                if (rd_strobe || wr_strobe) begin
                    if (first < 0) first = cnt;
                    slen++;
                end
                if (rd_strobe) saw_rd = 1'b1;
                if (wr_strobe) saw_wr = 1'b1;
                if (bus_oe) oelen++;
                if (done) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R3 done with no access expected", 1, 0);
                    end else begin
                        item_t it;
                        it = sb.pop_front();
                        check(first == it.first, {"R2 strobe start ", it.tag}, first, it.first);
                        check(slen == it.slen, {"R2 strobe width ", it.tag}, slen, it.slen);
                        check(cnt == it.done_at, {"R3 done time ", it.tag}, cnt, it.done_at);
                        check(oelen == it.oelen, {"R4 output enable cycles ", it.tag}, oelen, it.oelen);
                        check(saw_wr == it.wr && saw_rd == !it.wr, {"R4 R5 strobe kind ", it.tag},
                              {saw_wr, saw_rd}, {it.wr, !it.wr});
                        check(rd_data == it.rd, {"R5 read data ", it.tag}, rd_data, it.rd);
                    end
                    busy = 1'b0;
                    chk_done_low = 1'b1;
                end
            end
        end
    end

    // Driver: computes the expected item from the requirements, then runs the access
    task automatic do_access(input logic [3:0] a, input bit wr, input bit dsel,
                             input logic [15:0] din, input int rel, input int xgo,
                             input string tag);
        int p, s, t2, h, r, len;
        bit rdy;
        logic [31:0] tw;
        item_t it;
        p = 0;
        if (a == 4'h0) begin
            if (!dsel && fast_en0) p = 1;
            else if (dsel && fast_en1) p = 2;
        end
        tw  = (p == 1) ? d0_tim : (p == 2) ? d1_tim : cmd_tim;
        rdy = (p == 1) ? d0_rdy_en : (p == 2) ? d1_rdy_en : cmd_rdy_en;
        s = int'(tw[7:0]); t2 = int'(tw[15:8]); h = int'(tw[23:16]); r = int'(tw[31:24]);
        len = t2 + 1;
        if (rdy && rel >= 2 && rel - s - 1 > len) len = rel - s - 1;
        it.first   = s + 2;
        it.slen    = len;
        it.oelen   = wr ? (s + 1 + len + h + 1) : 0;
        it.done_at = s + len + h + r + 4;
        it.wr      = wr;
        if (!wr) last_rd = din;
        it.rd  = last_rd;
        it.tag = tag;
        sb.push_back(it);

        @(posedge clk); #1;
        addr = a; dir_wr = wr; dev_sel = dsel; bus_din = din;
        iordy_s = (rel >= 2) ? 1'b0 : 1'b1;
        go = 1'b1;
        @(posedge clk); #1;
        go = 1'b0;
        for (int k = 1; k < 400; k++) begin
            if (sb.size() == 0) break;
            @(posedge clk); #1;
            if (k == rel - 1) iordy_s = 1'b1;
            if (k == xgo) begin
                go = 1'b1; dev_sel = ~dev_sel; addr = addr ^ 4'h8; dir_wr = ~dir_wr;
            end
            if (k == xgo + 1) go = 1'b0;
        end
        go = 1'b0; iordy_s = 1'b1; dev_sel = dsel;
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        cmd_tim = pack_tim(2, 4, 1, 3);
        d0_tim  = pack_tim(1, 3, 2, 2);
        d1_tim  = pack_tim(3, 5, 0, 1);
        repeat (3) @(posedge clk);
        #1;
        check(!rd_strobe && !wr_strobe && !bus_oe && !done && rd_data == 16'h0,
              "R1 state in async reset", {rd_strobe, wr_strobe, bus_oe, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(!rd_strobe && !wr_strobe && !bus_oe && !done,
              "R1 idle after reset release", {rd_strobe, wr_strobe, bus_oe, done}, 0);

        // R7: command register read and write use the command profile
        do_access(4'h7, 1'b0, 1'b0, 16'hA5C3, 0, 0, "R7 cmd read");
        do_access(4'hA, 1'b1, 1'b0, 16'h1111, 0, 0, "R7 cmd write");
        // R7: data port with fast flag clear falls back
        do_access(4'h0, 1'b0, 1'b0, 16'h0F0F, 0, 0, "R7 data port fallback");
        // R6: fast device profiles
        fast_en0 = 1'b1; fast_en1 = 1'b1;
        do_access(4'h0, 1'b0, 1'b0, 16'h3C3C, 0, 0, "R6 dev0 read");
        do_access(4'h0, 1'b1, 1'b1, 16'h7777, 0, 0, "R6 dev1 write");
        do_access(4'h8, 1'b0, 1'b1, 16'h2468, 0, 0, "R7 non-data address with fast flags");
        // R8: stretch through ready on dev0 profile
        do_access(4'h0, 1'b0, 1'b0, 16'hBEEF, 20, 0, "R8 ready stretch");
        // R9: command profile has ready disabled
        do_access(4'h3, 1'b0, 1'b0, 16'hCAFE, 30, 0, "R9 ready ignored");
        // R10 R11: go and select change during an access
        do_access(4'h0, 1'b0, 1'b0, 16'h5A5A, 0, 3, "R10 R11 mid-access go");
        // R2: all counts zero
        d1_tim = pack_tim(0, 0, 0, 0);
        do_access(4'h0, 1'b0, 1'b1, 16'h9001, 0, 0, "R2 zero counts");
        do_access(4'h0, 1'b1, 1'b1, 16'h0000, 0, 0, "R2 zero counts write");

        // R1: synchronous reset in the middle of a read
        mon_en = 1'b0;
        addr = 4'h5; dir_wr = 1'b0; go = 1'b1;
        @(posedge clk); #1; go = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check(rd_strobe == 1'b1, "R1 read under way before sync reset", rd_strobe, 1);
        srst = 1'b1;
        @(posedge clk); #1; srst = 1'b0;
        check(!rd_strobe && !wr_strobe && !bus_oe && rd_data == 16'h0,
              "R1 sync reset clears outputs", {rd_strobe, wr_strobe, bus_oe}, 0);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done || rd_strobe) check(1'b0, "R1 activity after sync reset", 1, 0);
        end
        // R1: asynchronous reset during a write
        @(posedge clk); #1;
        addr = 4'h6; dir_wr = 1'b1; go = 1'b1;
        @(posedge clk); #1; go = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(bus_oe == 1'b1, "R4 write drives bus before async reset", bus_oe, 1);
        rst_n = 1'b0;
        #1;
        check(!rd_strobe && !wr_strobe && !bus_oe && !done,
              "R1 async reset clears outputs", {rd_strobe, wr_strobe, bus_oe, done}, 0);
        repeat (2) @(posedge clk);
        #1; rst_n = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (done || wr_strobe) check(1'b0, "R1 activity after async reset", 1, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule